// File: doc/BRIEF.md
# ASID-Tagged Associative Translation Buffer

This block is a 32-entry fully associative cache of address translations. Each slot holds a virtual page number, a physical frame number, an 8-bit address-space tag, a global flag, a valid flag, a dirty flag and three coherence-attribute bits. A lookup port compares a page number against every slot in parallel. A slot only hits if it is valid, its page number matches, and it is either global or tagged with the current address-space register. The registered result gives hit, slot index, frame number and attributes. Because slots are tagged, translations for several address spaces can share the array.

A management port serves the software that maintains the array. It has four operations: probe for the slot that matches a page number, read a slot, write a chosen slot, and write a slot chosen by the block's own replacement counter. A wired-count register keeps the lowest slots out of reach of the replacement counter, so that translations which must never miss stay resident. A flush input clears every valid flag in one cycle. A pulse on the base-register-write input also flushes, because a new page-table base makes every cached translation stale.

Both ports take a request with a valid strobe and always accept it: there is no ready signal and no back-pressure. Every request produces exactly one response, one cycle later, and responses come out in request order.

Top module: `xlt_tlb`

## Requirements
- R1: A lookup hits only if some slot is valid, its page number equals `lk_vpn`, and either its global flag is set or its tag equals the current address-space register. A global slot hits whatever the current tag is.
- R2: Two slots with the same page number and different tags can both be resident. Only the slot whose tag equals the current register hits, and with the current tag set to a third value neither slot hits.
- R3: `lk_rsp_valid` is high in exactly the cycle after each cycle with `lk_valid` high. On a hit that response carries the slot index, the frame number, the coherence bits and the dirty flag of the matching slot.
- R4: If several slots match a lookup, the response reports the lowest-numbered matching slot and raises `lk_multi`. `lk_multi` is never high without `lk_hit`.
- R5: `flush` or `base_wr` clears the valid flag of every slot, wired slots included. A lookup issued in the next cycle misses.
- R6: Probe (`mg_op` = 0) matches `mg_vpn` under the same rule as R1. It returns `mg_rsp_hit`=1 and the lowest matching index, or `mg_rsp_hit`=0 on a miss.
- R7: Read (`mg_op` = 1) returns every field of slot `mg_idx` on the `mg_rsp_*` outputs.
- R8: Indexed write (`mg_op` = 2) replaces slot `mg_idx` with the `mg_*` entry fields, and later lookups see the new contents. The response index equals `mg_idx`.
- R9: Random write (`mg_op` = 3) stores the entry in a slot whose index is at least the wired count and at most 31. That index is reported on `mg_rsp_idx`. With a wired count of 31, slot 31 is always chosen.
- R10: After reset every slot is invalid, the current tag and the wired count are 0, and both response strobes are low.
- R11: `mg_rsp_valid` is high in exactly the cycle after each cycle with `mg_valid` high.
- R12: A write issued in the same cycle as a flush is discarded: the target slot reads back invalid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear all valid flags |
| base_wr | input | 1 | Page-table base register written; flushes the array |
| cur_asid_we | input | 1 | Load the current address-space register |
| cur_asid_wdata | input | 8 | New current address-space tag |
| wired_we | input | 1 | Load the wired-count register |
| wired_wdata | input | 5 | Number of low slots excluded from random writes |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vpn | input | 19 | Lookup page number |
| lk_rsp_valid | output | 1 | Lookup response strobe |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | 5 | Matching slot index |
| lk_pfn | output | 24 | Frame number of the matching slot |
| lk_coh | output | 3 | Coherence bits of the matching slot |
| lk_dirty | output | 1 | Dirty flag of the matching slot |
| lk_multi | output | 1 | More than one slot matched |
| mg_valid | input | 1 | Management request strobe |
| mg_op | input | 2 | 0 probe, 1 read, 2 indexed write, 3 random write |
| mg_idx | input | 5 | Slot for read and indexed write |
| mg_vpn | input | 19 | Page number for probe or write |
| mg_pfn | input | 24 | Frame number to write |
| mg_asid | input | 8 | Tag to write |
| mg_glob | input | 1 | Global flag to write |
| mg_vld | input | 1 | Valid flag to write |
| mg_dirty | input | 1 | Dirty flag to write |
| mg_coh | input | 3 | Coherence bits to write |
| mg_rsp_valid | output | 1 | Management response strobe |
| mg_rsp_hit | output | 1 | Probe found a match |
| mg_rsp_idx | output | 5 | Probed, read or written slot index |
| mg_rsp_vpn | output | 19 | Page number of the reported slot |
| mg_rsp_pfn | output | 24 | Frame number of the reported slot |
| mg_rsp_asid | output | 8 | Tag of the reported slot |
| mg_rsp_glob | output | 1 | Global flag of the reported slot |
| mg_rsp_vld | output | 1 | Valid flag of the reported slot |
| mg_rsp_dirty | output | 1 | Dirty flag of the reported slot |
| mg_rsp_coh | output | 3 | Coherence bits of the reported slot |

## Verification
The same page number is looked up under three tag values against a pair of slots that differ only in tag. This separates a design that honours the tag from one that ignores it or returns the first page match. A global slot is looked up under an unrelated tag, and a duplicated page number exposes both the priority order and the multi-match flag. Random writes run with a wired count of 20 and then of 31, which checks both the folding range and its single-slot limit. Flushes are driven both through the flush pin and through a base-register write, one of them together with a write in the same cycle, and lookups of wired slots afterwards show that the flush clears every slot.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  parameter int XLT_VPN_W  = 19;
  parameter int XLT_PFN_W  = 24;
  parameter int XLT_ASID_W = 8;
  parameter int XLT_COH_W  = 3;

  typedef struct packed {
    logic [XLT_VPN_W-1:0]  vpn;
    logic [XLT_PFN_W-1:0]  pfn;
    logic [XLT_ASID_W-1:0] asid;
    logic                  glob;
    logic                  vld;
    logic                  dirty;
    logic [XLT_COH_W-1:0]  coh;
  } xlt_entry_t;

  typedef enum logic [1:0] {
    OP_PROBE = 2'd0,
    OP_READ  = 2'd1,
    OP_WIDX  = 2'd2,
    OP_WRND  = 2'd3
  } xlt_op_e;
endpackage

// File: rtl/xlt_match.sv
module xlt_match
  import xlt_pkg::*;
#(
  parameter int N = 32
) (
  input  xlt_entry_t [N-1:0]      tab,
  input  logic [XLT_VPN_W-1:0]    vpn,
  input  logic [XLT_ASID_W-1:0]   asid,
  output logic [N-1:0]            hit_vec
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    assign hit_vec[g] = tab[g].vld && (tab[g].vpn == vpn) &&
                        (tab[g].glob || (tab[g].asid == asid));
  end
endmodule

// File: rtl/xlt_prio.sv
module xlt_prio #(
  parameter int N     = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic             multi
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end

  assign any   = |vec;
  assign multi = |(vec & (vec - 1'b1));
endmodule

// File: rtl/xlt_victim.sv
module xlt_victim #(
  parameter int N     = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] wired,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= LAST;
    end else if (cnt_q <= wired || cnt_q == '0) begin
      cnt_q <= LAST;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign idx = (cnt_q < wired) ? LAST : cnt_q;
endmodule

// File: rtl/xlt_tlb.sv
module xlt_tlb
  import xlt_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  base_wr,
  input  logic                  cur_asid_we,
  input  logic [XLT_ASID_W-1:0] cur_asid_wdata,
  input  logic                  wired_we,
  input  logic [IDX_W-1:0]      wired_wdata,
  input  logic                  lk_valid,
  input  logic [XLT_VPN_W-1:0]  lk_vpn,
  output logic                  lk_rsp_valid,
  output logic                  lk_hit,
  output logic [IDX_W-1:0]      lk_idx,
  output logic [XLT_PFN_W-1:0]  lk_pfn,
  output logic [XLT_COH_W-1:0]  lk_coh,
  output logic                  lk_dirty,
  output logic                  lk_multi,
  input  logic                  mg_valid,
  input  logic [1:0]            mg_op,
  input  logic [IDX_W-1:0]      mg_idx,
  input  logic [XLT_VPN_W-1:0]  mg_vpn,
  input  logic [XLT_PFN_W-1:0]  mg_pfn,
  input  logic [XLT_ASID_W-1:0] mg_asid,
  input  logic                  mg_glob,
  input  logic                  mg_vld,
  input  logic                  mg_dirty,
  input  logic [XLT_COH_W-1:0]  mg_coh,
  output logic                  mg_rsp_valid,
  output logic                  mg_rsp_hit,
  output logic [IDX_W-1:0]      mg_rsp_idx,
  output logic [XLT_VPN_W-1:0]  mg_rsp_vpn,
  output logic [XLT_PFN_W-1:0]  mg_rsp_pfn,
  output logic [XLT_ASID_W-1:0] mg_rsp_asid,
  output logic                  mg_rsp_glob,
  output logic                  mg_rsp_vld,
  output logic                  mg_rsp_dirty,
  output logic [XLT_COH_W-1:0]  mg_rsp_coh
);
  xlt_entry_t [N_ENTRIES-1:0] tab_q;
  logic [XLT_ASID_W-1:0]      cur_asid_q;
  logic [IDX_W-1:0]           wired_q;

  // lookup path
  logic [N_ENTRIES-1:0] lk_vec;
  logic                 lk_any, lk_mul;
  logic [IDX_W-1:0]     lk_sel;

  xlt_match #(.N(N_ENTRIES)) u_lk_match (
    .tab(tab_q), .vpn(lk_vpn), .asid(cur_asid_q), .hit_vec(lk_vec)
  );
  xlt_prio #(.N(N_ENTRIES)) u_lk_prio (
    .vec(lk_vec), .any(lk_any), .idx(lk_sel), .multi(lk_mul)
  );

  // probe path
  logic [N_ENTRIES-1:0] pr_vec;
  logic                 pr_any, pr_mul;
  logic [IDX_W-1:0]     pr_sel;

  xlt_match #(.N(N_ENTRIES)) u_pr_match (
    .tab(tab_q), .vpn(mg_vpn), .asid(cur_asid_q), .hit_vec(pr_vec)
  );
  xlt_prio #(.N(N_ENTRIES)) u_pr_prio (
    .vec(pr_vec), .any(pr_any), .idx(pr_sel), .multi(pr_mul)
  );

  // replacement index
  logic [IDX_W-1:0] vic_idx;
  xlt_victim #(.N(N_ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .wired(wired_q), .idx(vic_idx)
  );

  // write path
  xlt_entry_t       wr_ent;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             clr_all;
  xlt_op_e          op;

  assign op      = xlt_op_e'(mg_op);
  assign clr_all = flush | base_wr;
  assign wr_ent  = '{vpn: mg_vpn, pfn: mg_pfn, asid: mg_asid, glob: mg_glob,
                     vld: mg_vld, dirty: mg_dirty, coh: mg_coh};
  assign wr_en   = mg_valid && (op == OP_WIDX || op == OP_WRND);
  assign wr_idx  = (op == OP_WRND) ? vic_idx : mg_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tab_q      <= '0;
      cur_asid_q <= '0;
      wired_q    <= '0;
    end else begin
      if (cur_asid_we) cur_asid_q <= cur_asid_wdata;
      if (wired_we)    wired_q    <= wired_wdata;
      if (clr_all) begin
        for (int i = 0; i < N_ENTRIES; i++) tab_q[i].vld <= 1'b0;
      end else if (wr_en) begin
        tab_q[wr_idx] <= wr_ent;
      end
    end
  end

  // lookup response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_rsp_valid <= 1'b0;
      lk_hit       <= 1'b0;
      lk_idx       <= '0;
      lk_pfn       <= '0;
      lk_coh       <= '0;
      lk_dirty     <= 1'b0;
      lk_multi     <= 1'b0;
    end else begin
      lk_rsp_valid <= lk_valid;
      lk_hit       <= lk_valid && lk_any;
      lk_multi     <= lk_valid && lk_mul;
      lk_idx       <= lk_any ? lk_sel : '0;
      lk_pfn       <= lk_any ? tab_q[lk_sel].pfn : '0;
      lk_coh       <= lk_any ? tab_q[lk_sel].coh : '0;
      lk_dirty     <= lk_any && tab_q[lk_sel].dirty;
    end
  end

  // management response
  xlt_entry_t       rsp_ent_d, rsp_ent_q;
  logic [IDX_W-1:0] rsp_idx_d;
  logic             rsp_hit_d;

  always_comb begin
    rsp_ent_d = '0;
    rsp_idx_d = '0;
    rsp_hit_d = 1'b0;
    unique case (op)
      OP_PROBE: begin
        rsp_hit_d = pr_any;
        rsp_idx_d = pr_any ? pr_sel : '0;
        rsp_ent_d = pr_any ? tab_q[pr_sel] : '0;
      end
      OP_READ: begin
        rsp_idx_d = mg_idx;
        rsp_ent_d = tab_q[mg_idx];
      end
      OP_WIDX, OP_WRND: begin
        rsp_idx_d = wr_idx;
        rsp_ent_d = wr_ent;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mg_rsp_valid <= 1'b0;
      mg_rsp_hit   <= 1'b0;
      mg_rsp_idx   <= '0;
      rsp_ent_q    <= '0;
    end else begin
      mg_rsp_valid <= mg_valid;
      if (mg_valid) begin
        mg_rsp_hit <= rsp_hit_d;
        mg_rsp_idx <= rsp_idx_d;
        rsp_ent_q  <= rsp_ent_d;
      end
    end
  end

  assign mg_rsp_vpn   = rsp_ent_q.vpn;
  assign mg_rsp_pfn   = rsp_ent_q.pfn;
  assign mg_rsp_asid  = rsp_ent_q.asid;
  assign mg_rsp_glob  = rsp_ent_q.glob;
  assign mg_rsp_vld   = rsp_ent_q.vld;
  assign mg_rsp_dirty = rsp_ent_q.dirty;
  assign mg_rsp_coh   = rsp_ent_q.coh;
endmodule

// File: rtl/xlt_tlb_chk.sv
module xlt_tlb_chk #(
  parameter int N     = 32,
  localparam int IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             base_wr,
  input logic             lk_valid,
  input logic             lk_rsp_valid,
  input logic             lk_hit,
  input logic             lk_multi,
  input logic             mg_valid,
  input logic [1:0]       mg_op,
  input logic             mg_rsp_valid,
  input logic [IDX_W-1:0] mg_rsp_idx,
  input logic [IDX_W-1:0] wired_q
);
  // R3: one response per lookup, one cycle later
  a_r3_lk_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_rsp_valid);
  a_r3_lk_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_rsp_valid);
  // R3: hit only accompanies a response
  a_r3_hit_needs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_rsp_valid |-> !lk_hit);
  // R4: multi-match implies a hit
  a_r4_multi_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit);
  // R5: lookup right after a flush misses
  a_r5_flush_miss: assert property (@(posedge clk) disable iff (!rst_n)
    ((flush || base_wr) ##1 lk_valid) |=> !lk_hit);
  // R9: random slot stays above the wired region
  a_r9_rand_above_wired: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_valid && mg_op == 2'd3) |=> (mg_rsp_idx >= $past(wired_q)));
  // R11: one management response per request
  a_r11_mg_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    mg_valid |=> mg_rsp_valid);
  a_r11_mg_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !mg_valid |=> !mg_rsp_valid);
endmodule

bind xlt_tlb xlt_tlb_chk #(.N(N_ENTRIES)) u_xlt_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .base_wr(base_wr),
  .lk_valid(lk_valid), .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit),
  .lk_multi(lk_multi), .mg_valid(mg_valid), .mg_op(mg_op),
  .mg_rsp_valid(mg_rsp_valid), .mg_rsp_idx(mg_rsp_idx), .wired_q(wired_q)
);

// File: tb/xlt_tlb_tb_top.sv
module xlt_tlb_tb_top;
  import xlt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush, base_wr, cur_asid_we, wired_we, lk_valid, mg_valid;
  logic [7:0]  cur_asid_wdata;
  logic [4:0]  wired_wdata, mg_idx;
  logic [18:0] lk_vpn, mg_vpn;
  logic [1:0]  mg_op;
  logic [23:0] mg_pfn;
  logic [7:0]  mg_asid;
  logic        mg_glob, mg_vld, mg_dirty;
  logic [2:0]  mg_coh;
  logic        lk_rsp_valid, lk_hit, lk_dirty, lk_multi;
  logic [4:0]  lk_idx;
  logic [23:0] lk_pfn;
  logic [2:0]  lk_coh;
  logic        mg_rsp_valid, mg_rsp_hit, mg_rsp_glob, mg_rsp_vld, mg_rsp_dirty;
  logic [4:0]  mg_rsp_idx;
  logic [18:0] mg_rsp_vpn;
  logic [23:0] mg_rsp_pfn;
  logic [7:0]  mg_rsp_asid;
  logic [2:0]  mg_rsp_coh;

  always #5 clk = ~clk;

  xlt_tlb dut_i (.*);

  typedef struct {
    int cyc; bit hit; int idx; int pfn; int coh; bit dirty; bit multi;
  } lk_exp_t;
  typedef struct {
    int cyc; int op; bit hit; int idx; xlt_entry_t ent; int wmin;
  } mg_exp_t;

  lk_exp_t    lk_q[$];
  mg_exp_t    mg_q[$];
  xlt_entry_t model[32];
  int m_asid = 0, m_wired = 0;
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic xlt_entry_t mk(int vpn, int pfn, int asid, bit g, bit d, int coh);
    xlt_entry_t e;
    e.vpn = 19'(vpn); e.pfn = 24'(pfn); e.asid = 8'(asid);
    e.glob = g; e.vld = 1'b1; e.dirty = d; e.coh = 3'(coh);
    return e;
  endfunction

  function automatic lk_exp_t predict(int vpn);
    lk_exp_t e;
    int n = 0;
    e = '{default: 0};
    for (int i = 0; i < 32; i++) begin
      if (model[i].vld && model[i].vpn == 19'(vpn) &&
          (model[i].glob || model[i].asid == 8'(m_asid))) begin
        if (n == 0) begin
          e.idx = i; e.pfn = int'(model[i].pfn);
          e.coh = int'(model[i].coh); e.dirty = model[i].dirty;
        end
        n++;
      end
    end
    e.hit = (n > 0); e.multi = (n > 1);
    return e;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (lk_rsp_valid) begin
        if (lk_q.size() == 0) chk("R3", "unexpected lookup response", 1, 0);
        else begin
          lk_exp_t e;
          e = lk_q.pop_front();
          chk("R3", "lookup latency", 64'(cyc), 64'(e.cyc + 1));
          chk("R1", "lookup hit", 64'(lk_hit), 64'(e.hit));
          chk("R4", "multi flag", 64'(lk_multi), 64'(e.multi));
          if (e.hit) begin
            chk("R4", "lookup index", 64'(lk_idx), 64'(e.idx));
            chk("R3", "lookup pfn", 64'(lk_pfn), 64'(e.pfn));
            chk("R3", "lookup coh", 64'(lk_coh), 64'(e.coh));
            chk("R3", "lookup dirty", 64'(lk_dirty), 64'(e.dirty));
          end
        end
      end else if (lk_q.size() > 0 && lk_q[0].cyc + 1 <= cyc) begin
        chk("R3", "missing lookup response", 0, 1);
        void'(lk_q.pop_front());
      end
      if (mg_rsp_valid) begin
        if (mg_q.size() == 0) chk("R11", "unexpected mgmt response", 1, 0);
        else begin
          mg_exp_t e;
          e = mg_q.pop_front();
          chk("R11", "mgmt latency", 64'(cyc), 64'(e.cyc + 1));
          case (e.op)
            0: begin
              chk("R6", "probe hit", 64'(mg_rsp_hit), 64'(e.hit));
              if (e.hit) chk("R6", "probe index", 64'(mg_rsp_idx), 64'(e.idx));
            end
            1: begin
              chk("R7", "read vld", 64'(mg_rsp_vld), 64'(e.ent.vld));
              if (e.ent.vld)
                chk("R7", "read entry",
                    64'({mg_rsp_vpn, mg_rsp_pfn, mg_rsp_asid, mg_rsp_glob,
                         mg_rsp_vld, mg_rsp_dirty, mg_rsp_coh}), 64'(e.ent));
            end
            2: chk("R8", "write index", 64'(mg_rsp_idx), 64'(e.idx));
            default: begin
              chk("R9", "random index in range",
                  64'(mg_rsp_idx >= 5'(e.wmin)), 64'(1));
              model[mg_rsp_idx] = e.ent;
            end
          endcase
        end
      end else if (mg_q.size() > 0 && mg_q[0].cyc + 1 <= cyc) begin
        chk("R11", "missing mgmt response", 0, 1);
        void'(mg_q.pop_front());
      end
    end
  end

  task automatic clr();
    flush = 0; base_wr = 0; cur_asid_we = 0; wired_we = 0;
    lk_valid = 0; mg_valid = 0; cur_asid_wdata = 0; wired_wdata = 0;
    lk_vpn = 0; mg_op = 0; mg_idx = 0; mg_vpn = 0; mg_pfn = 0; mg_asid = 0;
    mg_glob = 0; mg_vld = 0; mg_dirty = 0; mg_coh = 0;
  endtask

  task automatic put_ent(xlt_entry_t e);
    mg_vpn = e.vpn; mg_pfn = e.pfn; mg_asid = e.asid; mg_glob = e.glob;
    mg_vld = e.vld; mg_dirty = e.dirty; mg_coh = e.coh;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); clr(); end
  endtask

  task automatic op_asid(int a);
    @(negedge clk); clr(); cur_asid_we = 1; cur_asid_wdata = 8'(a); m_asid = a;
  endtask

  task automatic op_wired(int w);
    @(negedge clk); clr(); wired_we = 1; wired_wdata = 5'(w); m_wired = w;
  endtask

  task automatic op_look(int vpn);
    lk_exp_t e;
    @(negedge clk); clr(); lk_valid = 1; lk_vpn = 19'(vpn);
    e = predict(vpn); e.cyc = cyc; lk_q.push_back(e);
  endtask

  task automatic op_write(int idx, xlt_entry_t ent);
    mg_exp_t e;
    @(negedge clk); clr(); mg_valid = 1; mg_op = 2'd2; mg_idx = 5'(idx); put_ent(ent);
    e = '{cyc: cyc, op: 2, hit: 0, idx: idx, ent: ent, wmin: 0};
    mg_q.push_back(e); model[idx] = ent;
  endtask

  task automatic op_rand(xlt_entry_t ent);
    mg_exp_t e;
    @(negedge clk); clr(); mg_valid = 1; mg_op = 2'd3; put_ent(ent);
    e = '{cyc: cyc, op: 3, hit: 0, idx: 0, ent: ent, wmin: m_wired};
    mg_q.push_back(e);
    idle(1);
  endtask

  task automatic op_probe(int vpn);
    mg_exp_t e;
    lk_exp_t p;
    @(negedge clk); clr(); mg_valid = 1; mg_op = 2'd0; mg_vpn = 19'(vpn);
    p = predict(vpn);
    e = '{cyc: cyc, op: 0, hit: p.hit, idx: p.idx, ent: '0, wmin: 0};
    mg_q.push_back(e);
  endtask

  task automatic op_read(int idx);
    mg_exp_t e;
    @(negedge clk); clr(); mg_valid = 1; mg_op = 2'd1; mg_idx = 5'(idx);
    e = '{cyc: cyc, op: 1, hit: 0, idx: idx, ent: model[idx], wmin: 0};
    mg_q.push_back(e);
  endtask

  task automatic op_flush(bit via_base);
    @(negedge clk); clr();
    if (via_base) base_wr = 1; else flush = 1;
    for (int i = 0; i < 32; i++) model[i].vld = 0;
  endtask

  task automatic op_flush_write(int idx, xlt_entry_t ent);
    mg_exp_t e;
    @(negedge clk); clr(); flush = 1;
    mg_valid = 1; mg_op = 2'd2; mg_idx = 5'(idx); put_ent(ent);
    e = '{cyc: cyc, op: 2, hit: 0, idx: idx, ent: ent, wmin: 0};
    mg_q.push_back(e);
    for (int i = 0; i < 32; i++) model[i].vld = 0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    chk("R10", "lk_rsp_valid after reset", 64'(lk_rsp_valid), 0);
    chk("R10", "mg_rsp_valid after reset", 64'(mg_rsp_valid), 0);
    op_read(0); op_read(31);
    op_look(19'h10);

    // R1 R2: same page, two tags
    op_asid(1);
    op_write(3, mk(19'h10, 100, 1, 0, 1, 5));
    op_write(7, mk(19'h10, 170, 2, 0, 0, 2));
    op_look(19'h10);
    op_asid(2);
    op_look(19'h10);
    op_asid(3);
    op_look(19'h10);
    // R1: global slot under unrelated tag
    op_write(4, mk(19'h22, 333, 9, 1, 0, 7));
    op_look(19'h22);
    // R6: probe miss then hit
    op_probe(19'h10);
    op_asid(1);
    op_probe(19'h10);
    op_probe(19'h22);
    // R7: read full entry
    op_read(7);
    // R8: overwrite then look up
    op_write(3, mk(19'h10, 24'h55, 1, 0, 0, 1));
    op_look(19'h10);
    // R4: duplicates, lowest index wins; back-to-back lookups (R3)
    op_write(12, mk(19'h33, 1200, 1, 0, 0, 0));
    op_write(9, mk(19'h33, 900, 1, 0, 1, 3));
    op_look(19'h33);
    op_look(19'h33);
    op_probe(19'h33);
    // R9: random writes above wired count 20
    op_wired(20);
    for (int k = 0; k < 6; k++) op_rand(mk(19'h100 + k, 4000 + k, 1, 0, 0, 0));
    for (int k = 0; k < 6; k++) op_look(19'h100 + k);
    // R9: wired 31 forces slot 31
    op_wired(31);
    op_rand(mk(19'h200, 777, 1, 0, 0, 4));
    op_rand(mk(19'h201, 778, 1, 0, 0, 4));
    op_read(31);
    op_look(19'h201);
    // R12: write with flush is discarded
    op_write(1, mk(19'h44, 44, 1, 0, 0, 0));
    op_flush_write(1, mk(19'h45, 45, 1, 0, 0, 0));
    op_read(1);
    op_look(19'h45);
    // R5: flush clears wired slots too
    op_write(2, mk(19'h50, 50, 1, 0, 0, 0));
    op_write(25, mk(19'h51, 51, 1, 1, 0, 0));
    op_look(19'h50);
    op_flush(0);
    op_look(19'h50);
    op_look(19'h51);
    // R5: base register write flushes
    op_write(2, mk(19'h50, 52, 1, 0, 0, 0));
    op_look(19'h50);
    op_flush(1);
    op_look(19'h50);
    op_read(2);
    idle(4);
    chk("R3", "lookup queue drained", 64'(lk_q.size()), 0);
    chk("R11", "mgmt queue drained", 64'(mg_q.size()), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule